// File: doc/BRIEF.md
# Shared Bus Arbiter with Atomic Lock

This block decides which of several processors owns a shared memory bus for each bus cycle. Every master drives a request line and a lock line. When no lock is held, the arbiter settles ownership again at each cycle, rotating among requesters in round-robin order. A master that wants an indivisible read-modify-write, such as a test-and-set or an exchange, raises its lock along with its request. Once it is granted, the arbiter keeps that master on the bus for as long as the lock stays high. The read and the write of the sequence therefore land on back-to-back cycles, and no other processor can touch memory between them.

The grant is registered. The request and lock values present before a clock edge decide the grant for the bus cycle that starts at that edge. Lock is only looked at for the master that currently holds the grant. When that master drops its lock, arbitration resumes at the next edge.

Top module: `bus_lock_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no grant bit is set. The first arbitration after reset favours master 0.
- R2: The grant vector has at most one bit set in every cycle.
- R3: Outside a lock hold, a master is granted in a cycle only if its request was high before the edge that opened that cycle.
- R4: Outside a lock hold, the new grant goes to the first requesting master after the last granted one, searching upward in index and wrapping from N-1 to 0.
- R5: If no master requests and no lock hold is in force, the next cycle has no grant, and the round-robin position is left unchanged.
- R6: If the granted master has its lock high before an edge, the same master is granted in the next cycle, whatever the other masters request.
- R7: When the granted master lowers its lock while another master requests, the next cycle is granted to a different master.
- R8: Two masters that each perform read-then-write increments of a shared word under lock never lose an update. The final value equals the total number of increments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one bus cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Per-master bus request |
| lock | input | N | Per-master hold request for an atomic sequence |
| gnt | output | N | One-hot (or zero) per-cycle bus grant |

## Verification
Each grant is due exactly one clock edge after the request and lock values that decide it. The bench drives inputs on the falling edge and compares the grant on the next falling edge, half a period after the rising edge that loads it. The expected grant comes from an arithmetic round-robin model with a lock-hold rule, stepped once per cycle over all 64 request/lock combinations of a three-master setup, in several orders. In the atomic-increment run, the master holding the bus is checked to be granted again on the cycle right after its read, and the shared word is compared with the increment count at the end.

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] lock,
  output logic [N-1:0] gnt
);

  logic [W-1:0] last_q;
  logic [W-1:0] pick;
  logic         found;
  logic         held;

  assign held = |(gnt & lock);

  always_comb begin
    found = 1'b0;
    pick  = last_q;
    for (int i = 1; i <= N; i++) begin
      if (!found && req[(int'(last_q) + i) % N]) begin
        found = 1'b1;
        pick  = W'((int'(last_q) + i) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt    <= '0;
      last_q <= W'(N - 1);
    end else if (held) begin
      gnt    <= gnt;
    end else if (found) begin
      gnt       <= '0;
      gnt[pick] <= 1'b1;
      last_q    <= pick;
    end else begin
      gnt    <= '0;
    end
  end

endmodule

module bus_lock_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] lock,
  input logic [N-1:0] gnt
);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> gnt == '0);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

  a_r3_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(gnt & lock)) |=> ((gnt & $past(req)) == gnt));

  a_r5_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(gnt & lock)) && req == '0) |=> gnt == '0);

  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & lock)) |=> gnt == $past(gnt));

  a_r7_release_yields: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gnt & ~lock)) && (|(req & ~gnt))) |=> !(|(gnt & $past(gnt))));

endmodule

bind bus_lock_arbiter bus_lock_arbiter_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .gnt(gnt)
);

// File: tb/sim_bus_lock_arbiter.sv
module sim_bus_lock_arbiter;
  localparam int N = 3;
  localparam int PERIOD = 10;
  localparam int INCS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] lock = '0;
  logic [N-1:0] gnt;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;
  int exp_g = -1;
  int exp_last = N - 1;

  bus_lock_arbiter #(.N(N)) u0 (.clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .gnt(gnt));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] vec(int g);
    logic [N-1:0] v = '0;
    if (g >= 0) v[g] = 1'b1;
    return v;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gnt actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(logic [N-1:0] r, logic [N-1:0] l);
    int nxt;
    string tag;
    req = r;
    lock = l;
    if (exp_g >= 0 && l[exp_g]) begin
      nxt = exp_g;
      tag = "R6";
    end else begin
      nxt = -1;
      for (int i = 1; i <= N; i++)
        if (nxt < 0 && r[(exp_last + i) % N]) nxt = (exp_last + i) % N;
      if (nxt < 0) tag = "R5";
      else if (exp_g >= 0 && (r & ~vec(exp_g)) != 0) tag = "R7";
      else tag = "R4";
      if (nxt >= 0) exp_last = nxt;
    end
    exp_g = nxt;
    @(negedge clk);
    chk(tag, gnt, vec(exp_g));
    checks++;
    if (!$onehot0(gnt)) begin
      errors++;
      $display("FAIL R2 gnt actual %b expected at most one bit", gnt);
    end
    checks++;
    if (tag != "R6" && (gnt & ~r) != 0) begin
      errors++;
      $display("FAIL R3 gnt actual %b expected subset of req %b", gnt, r);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    int mem;
    int val [2];
    int ph [2];
    int cnt [2];
    bit rest [2];
    repeat (3) @(negedge clk);
    chk("R1", gnt, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", gnt, '0);
    step(3'b111, 3'b000);
    chk("R1", gnt, 3'b001);
    step(3'b000, 3'b000);
    step(3'b111, 3'b000);
    chk("R5", gnt, 3'b010);
    for (int pass = 0; pass < 4; pass++)
      for (int v = 0; v < 64; v++) begin
        logic [5:0] code;
        code = 6'((v * 37 + pass * 11) % 64);
        step(code[2:0], code[5:3]);
      end
    step(3'b000, 3'b000);

    mem = 0;
    for (int k = 0; k < 2; k++) begin
      val[k] = 0; ph[k] = 0; cnt[k] = 0; rest[k] = 1'b0;
    end
    req = 3'b111;
    lock = 3'b011;
    for (int c = 0; c < 4000 && (cnt[0] < INCS || cnt[1] < INCS); c++) begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        rest[k] = 1'b0;
        if (ph[k] == 1) chk("R6", gnt, vec(k));
        if (gnt[k]) begin
          if (ph[k] == 0) begin
            val[k] = mem;
            ph[k] = 1;
          end else begin
            mem = val[k] + 1;
            ph[k] = 0;
            cnt[k]++;
            rest[k] = 1'b1;
          end
        end
        req[k] = (cnt[k] < INCS) && !rest[k];
        lock[k] = req[k];
      end
    end
    checks++;
    if (mem != 2 * INCS) begin
      errors++;
      $display("FAIL R8 shared word actual %0d expected %0d", mem, 2 * INCS);
    end
    finish_run();
  end
endmodule